// File: doc/BRIEF.md
# 4B/5B PCS Coder with Symbol Checks

This block is the coding stage of a 100 Mb/s physical coding sublayer. On the transmit side it turns a nibble stream, qualified by an enable and an error input, into 5-bit code groups. Each packet is wrapped in a two-group start delimiter and a two-group end delimiter, and idle groups fill the line between packets. A test mode replaces the halt group sent on a transmit error with deliberately invalid code groups, so that a far-end receiver's error handling can be exercised.

On the receive side it takes one aligned 5-bit code group per cycle. It sorts each group as data, control or invalid, and tracks the start and end delimiters to drive a carrier indication. It outputs decoded nibbles with a valid strobe, a per-cycle receive error, a false-carrier pulse, and two sticky flags that record invalid groups and halt groups until management clears them with a read strobe. Scrambling, line coding, serialisation and symbol alignment belong to neighbouring blocks.

Top module: `pcs_4b5b_coder`

## Requirements
- R1: Inside a packet, with no transmit error, nibble n is sent as: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101. tx_code_o shows the group in the cycle after the inputs are sampled.
- R2: While tx_en_i is low and no packet is in progress, tx_code_o is I (11111). When tx_en_i rises, J (11000) and then K (10001) are sent in place of the first two nibbles.
- R3: When tx_en_i is sampled low during the data phase, T (01101) and then R (00111) are sent, followed by I.
- R4: With test_inv_i low, a data-phase cycle with tx_er_i high sends H (00100).
- R5: With test_inv_i high, each data-phase cycle with tx_er_i high sends the next value of the invalid set, in the order 00000, 00001, 00010, 00011, 00101, 00110, 01000, 01100, 10000, 11001, and then wraps. Cycles without tx_er_i do not advance the order. With test_inv_i low, tx_code_o is never an invalid group.
- R6: On receive, J followed by K raises crs_o in the cycle after K. Inside a packet, a data group gives rx_dv_o high and rxd_o equal to its nibble one cycle later. rx_dv_o is never high outside a packet.
- R7: A J that is not followed directly by K gives a one-cycle false_carrier_o pulse, and crs_o stays low.
- R8: T followed by R ends the packet, and crs_o falls in the cycle after R. A T followed by anything other than R gives a one-cycle rx_er_o pulse, and the packet continues.
- R9: An invalid group received inside a packet gives rx_er_o high for one cycle, with rx_dv_o low.
- R10: Any invalid group received sets inv_flag_o, and any H group received sets halt_flag_o, whether or not a packet is in progress. Each flag is visible in the cycle after the group.
- R11: The flags hold until clr_i is high for a cycle. If a new event coincides with clr_i, the flag stays set.
- R12: After reset, tx_code_o is I and every receive output and flag is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Symbol clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit nibble enable |
| tx_er_i | input | 1 | Transmit error for this nibble slot |
| txd_i | input | 4 | Transmit nibble |
| test_inv_i | input | 1 | Send invalid groups on transmit error |
| tx_code_o | output | 5 | Transmit code group |
| rx_code_i | input | 5 | Received aligned code group |
| rxd_o | output | 4 | Received nibble |
| rx_dv_o | output | 1 | Received nibble valid |
| rx_er_o | output | 1 | Receive error for this cycle |
| crs_o | output | 1 | Packet in progress |
| false_carrier_o | output | 1 | Start delimiter not completed |
| clr_i | input | 1 | Management read strobe, clears flags |
| inv_flag_o | output | 1 | Sticky invalid-group flag |
| halt_flag_o | output | 1 | Sticky halt-group flag |

## Verification
Every output here sits one register after its inputs. A transmit nibble sampled at one rising edge appears on tx_code_o after that edge. A received group sampled at an edge updates the receive strobes, crs_o and the flags after that same edge. The bench changes inputs on the falling edge, waits for one rising edge, and compares at the next falling edge. Every expected group, nibble and strobe therefore belongs to exactly the inputs applied half a cycle before the rising edge that produced it. The invalid sequence and the code table are rebuilt in the bench by counting through all 32 values.

// File: rtl/pcs45_pkg.sv
package pcs45_pkg;
  localparam int NIB_W     = 4;
  localparam int CODE_W    = 5;
  localparam int NUM_CODES = 1 << CODE_W;
  localparam int NUM_NIB   = 1 << NIB_W;
  localparam int NUM_INV   = 10;
  localparam int INV_IDX_W = $clog2(NUM_INV);

  localparam logic [CODE_W-1:0] C_I = 5'b11111;
  localparam logic [CODE_W-1:0] C_J = 5'b11000;
  localparam logic [CODE_W-1:0] C_K = 5'b10001;
  localparam logic [CODE_W-1:0] C_T = 5'b01101;
  localparam logic [CODE_W-1:0] C_R = 5'b00111;
  localparam logic [CODE_W-1:0] C_H = 5'b00100;

  typedef enum logic [2:0] {
    SYM_DATA, SYM_I, SYM_J, SYM_K, SYM_T, SYM_R, SYM_H, SYM_BAD
  } sym_e;

  typedef struct packed {
    sym_e             kind;
    logic [NIB_W-1:0] nib;
  } sym_t;

  function automatic logic [CODE_W-1:0] enc_nib(input logic [NIB_W-1:0] n);
    logic [CODE_W-1:0] c;
    case (n)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction

  function automatic sym_t classify(input logic [CODE_W-1:0] c);
    sym_t s;
    s.kind = SYM_BAD;
    s.nib  = '0;
    for (int i = 0; i < NUM_NIB; i++) begin
      if (enc_nib(NIB_W'(i)) == c) begin
        s.kind = SYM_DATA;
        s.nib  = NIB_W'(i);
      end
    end
    case (c)
      C_I: s.kind = SYM_I;
      C_J: s.kind = SYM_J;
      C_K: s.kind = SYM_K;
      C_T: s.kind = SYM_T;
      C_R: s.kind = SYM_R;
      C_H: s.kind = SYM_H;
      default: ;
    endcase
    return s;
  endfunction

  // idx-th invalid group in ascending code order
  function automatic logic [CODE_W-1:0] nth_invalid(input logic [INV_IDX_W-1:0] idx);
    logic [CODE_W-1:0] r;
    int k;
    r = '0;
    k = 0;
    for (int c = 0; c < NUM_CODES; c++) begin
      if (classify(CODE_W'(c)).kind == SYM_BAD) begin
        if (k == int'(idx)) r = CODE_W'(c);
        k++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/pcs_tx_enc.sv
module pcs_tx_enc
  import pcs45_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              tx_er_i,
  input  logic [NIB_W-1:0]  txd_i,
  input  logic              test_inv_i,
  output logic [CODE_W-1:0] code_o
);
  typedef enum logic [1:0] {TX_IDLE, TX_SSD2, TX_DATA, TX_ESD2} tx_st_e;

  tx_st_e                st_q, st_d;
  logic [CODE_W-1:0]     code_q, code_d;
  logic [INV_IDX_W-1:0]  idx_q, idx_d;

  always_comb begin
    st_d   = st_q;
    code_d = C_I;
    idx_d  = idx_q;
    case (st_q)
      TX_IDLE: begin
        if (tx_en_i) begin
          code_d = C_J;
          st_d   = TX_SSD2;
        end
      end
      TX_SSD2: begin
        code_d = C_K;
        st_d   = TX_DATA;
      end
      TX_DATA: begin
        if (!tx_en_i) begin
          code_d = C_T;
          st_d   = TX_ESD2;
        end else if (tx_er_i && test_inv_i) begin
          code_d = nth_invalid(idx_q);
          idx_d  = (idx_q == INV_IDX_W'(NUM_INV - 1)) ? '0 : idx_q + 1'b1;
        end else if (tx_er_i) begin
          code_d = C_H;
        end else begin
          code_d = enc_nib(txd_i);
        end
      end
      default: begin
        code_d = C_R;
        st_d   = TX_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= TX_IDLE;
      code_q <= C_I;
      idx_q  <= '0;
    end else begin
      st_q   <= st_d;
      code_q <= code_d;
      idx_q  <= idx_d;
    end
  end

  assign code_o = code_q;
endmodule

// File: rtl/pcs_rx_dec.sv
module pcs_rx_dec
  import pcs45_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic [NIB_W-1:0]  rxd_o,
  output logic              dv_o,
  output logic              er_o,
  output logic              crs_o,
  output logic              fc_o,
  output logic              inv_ev_o,
  output logic              halt_ev_o
);
  typedef enum logic [1:0] {RX_IDLE, RX_J, RX_PKT, RX_T} rx_st_e;

  rx_st_e           st_q, st_d;
  sym_t             sym;
  logic [NIB_W-1:0] rxd_q, rxd_d;
  logic             dv_q, dv_d, er_q, er_d, crs_q, crs_d, fc_q, fc_d;

  assign sym = classify(code_i);

  always_comb begin
    st_d  = st_q;
    rxd_d = '0;
    dv_d  = 1'b0;
    er_d  = 1'b0;
    fc_d  = 1'b0;
    case (st_q)
      RX_IDLE: if (sym.kind == SYM_J) st_d = RX_J;
      RX_J: begin
        if (sym.kind == SYM_K) begin
          st_d = RX_PKT;
        end else begin
          fc_d = 1'b1;
          st_d = RX_IDLE;
        end
      end
      RX_PKT: begin
        case (sym.kind)
          SYM_DATA: begin
            dv_d  = 1'b1;
            rxd_d = sym.nib;
          end
          SYM_BAD: er_d = 1'b1;
          SYM_T:   st_d = RX_T;
          default: ;
        endcase
      end
      default: begin
        if (sym.kind == SYM_R) begin
          st_d = RX_IDLE;
        end else begin
          er_d = 1'b1;
          st_d = RX_PKT;
        end
      end
    endcase
    crs_d = (st_d == RX_PKT) || (st_d == RX_T);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= RX_IDLE;
      rxd_q <= '0;
      dv_q  <= 1'b0;
      er_q  <= 1'b0;
      crs_q <= 1'b0;
      fc_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      rxd_q <= rxd_d;
      dv_q  <= dv_d;
      er_q  <= er_d;
      crs_q <= crs_d;
      fc_q  <= fc_d;
    end
  end

  assign rxd_o     = rxd_q;
  assign dv_o      = dv_q;
  assign er_o      = er_q;
  assign crs_o     = crs_q;
  assign fc_o      = fc_q;
  assign inv_ev_o  = (sym.kind == SYM_BAD);
  assign halt_ev_o = (sym.kind == SYM_H);
endmodule

// File: rtl/pcs_sticky_flags.sv
module pcs_sticky_flags #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ev_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic q;
    // set wins over clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= ev_i[g] | (q & ~clr_i);
    end
    assign flag_o[g] = q;
  end
endmodule

// File: rtl/pcs_4b5b_coder.sv
module pcs_4b5b_coder
  import pcs45_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              tx_er_i,
  input  logic [NIB_W-1:0]  txd_i,
  input  logic              test_inv_i,
  output logic [CODE_W-1:0] tx_code_o,
  input  logic [CODE_W-1:0] rx_code_i,
  output logic [NIB_W-1:0]  rxd_o,
  output logic              rx_dv_o,
  output logic              rx_er_o,
  output logic              crs_o,
  output logic              false_carrier_o,
  input  logic              clr_i,
  output logic              inv_flag_o,
  output logic              halt_flag_o
);
  logic       inv_ev, halt_ev;
  logic [1:0] flags;

  pcs_tx_enc u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_en_i    (tx_en_i),
    .tx_er_i    (tx_er_i),
    .txd_i      (txd_i),
    .test_inv_i (test_inv_i),
    .code_o     (tx_code_o)
  );

  pcs_rx_dec u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .code_i    (rx_code_i),
    .rxd_o     (rxd_o),
    .dv_o      (rx_dv_o),
    .er_o      (rx_er_o),
    .crs_o     (crs_o),
    .fc_o      (false_carrier_o),
    .inv_ev_o  (inv_ev),
    .halt_ev_o (halt_ev)
  );

  pcs_sticky_flags #(.N(2)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   ({halt_ev, inv_ev}),
    .clr_i  (clr_i),
    .flag_o (flags)
  );

  assign inv_flag_o  = flags[0];
  assign halt_flag_o = flags[1];
endmodule

// File: rtl/pcs_4b5b_coder_chk.sv
module pcs_4b5b_coder_chk
  import pcs45_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_en_i,
  input logic              test_inv_i,
  input logic [CODE_W-1:0] tx_code_o,
  input logic [CODE_W-1:0] rx_code_i,
  input logic              rx_dv_o,
  input logic              crs_o,
  input logic              false_carrier_o,
  input logic              clr_i,
  input logic              inv_flag_o,
  input logic              halt_flag_o
);
  AST_SSD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_code_o == C_I && tx_en_i) |=> tx_code_o == C_J); // R2
  AST_SSD_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_code_o == C_J |=> tx_code_o == C_K); // R2
  AST_ESD_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_code_o == C_T |=> tx_code_o == C_R); // R3
  AST_NO_STRAY_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_inv_i |=> classify(tx_code_o).kind != SYM_BAD); // R5
  AST_DV_IN_PACKET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dv_o |-> crs_o); // R6
  AST_FALSE_CARRIER_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    false_carrier_o |-> !crs_o); // R7
  AST_INV_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    classify(rx_code_i).kind == SYM_BAD |=> inv_flag_o); // R10
  AST_HALT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_code_i == C_H |=> halt_flag_o); // R10
  AST_INV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_flag_o && !clr_i) |=> inv_flag_o); // R11
  AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_flag_o && !clr_i) |=> halt_flag_o); // R11
endmodule

bind pcs_4b5b_coder pcs_4b5b_coder_chk chk_i (.*);

// File: tb/pcs_4b5b_coder_tb_top.sv
module pcs_4b5b_coder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0, tx_er = 1'b0, test_inv = 1'b0, clr = 1'b0;
  logic [3:0] txd = '0;
  logic [4:0] rx_code = 5'b11111;
  logic [4:0] tx_code;
  logic [3:0] rxd;
  logic       rx_dv, rx_er, crs, fc, inv_flag, halt_flag;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  pcs_4b5b_coder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .tx_er_i(tx_er), .txd_i(txd),
    .test_inv_i(test_inv), .tx_code_o(tx_code), .rx_code_i(rx_code), .rxd_o(rxd),
    .rx_dv_o(rx_dv), .rx_er_o(rx_er), .crs_o(crs), .false_carrier_o(fc),
    .clr_i(clr), .inv_flag_o(inv_flag), .halt_flag_o(halt_flag)
  );

  function automatic logic [4:0] tbl(input int n);
    case (n)
      0: return 5'b11110;  1: return 5'b01001;  2: return 5'b10100;  3: return 5'b10101;
      4: return 5'b01010;  5: return 5'b01011;  6: return 5'b01110;  7: return 5'b01111;
      8: return 5'b10010;  9: return 5'b10011; 10: return 5'b10110; 11: return 5'b10111;
      12: return 5'b11010; 13: return 5'b11011; 14: return 5'b11100; default: return 5'b11101;
    endcase
  endfunction

  function automatic int data_of(input logic [4:0] c);
    for (int n = 0; n < 16; n++) if (tbl(n) == c) return n;
    return -1;
  endfunction

  function automatic bit is_ctl(input logic [4:0] c);
    return c == 5'b11111 || c == 5'b11000 || c == 5'b10001 ||
           c == 5'b01101 || c == 5'b00111 || c == 5'b00100;
  endfunction

  function automatic logic [4:0] inv_at(input int k);
    int seen = 0;
    for (int c = 0; c < 32; c++) begin
      if (data_of(5'(c)) < 0 && !is_ctl(5'(c))) begin
        if (seen == k) return 5'(c);
        seen++;
      end
    end
    return '0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tx_step(input bit en, input bit er, input int nib, input logic [4:0] exp, input string req);
    tx_en = en; tx_er = er; txd = 4'(nib);
    tick();
    chk(req, tx_code, exp);
  endtask

  task automatic rx_step(input logic [4:0] c);
    rx_code = c;
    tick();
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int k;
    #23;
    // R12 reset state
    chk("R12 tx", tx_code, 5'b11111);
    chk("R12 rx", {rxd, rx_dv, rx_er, crs, fc, inv_flag, halt_flag}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 idle, then start delimiter
    tx_step(0, 0, 3, 5'b11111, "R2 idle");
    tx_step(0, 0, 7, 5'b11111, "R2 idle");
    tx_step(1, 0, 0, 5'b11000, "R2 J");
    tx_step(1, 0, 1, 5'b10001, "R2 K");
    // R1 all sixteen nibbles
    for (int i = 2; i < 18; i++) tx_step(1, 0, i % 16, tbl(i % 16), "R1 data");
    // R3 end delimiter
    tx_step(0, 0, 0, 5'b01101, "R3 T");
    tx_step(0, 0, 0, 5'b00111, "R3 R");
    tx_step(0, 0, 0, 5'b11111, "R3 I");

    // R4 halt on error
    tx_step(1, 0, 0, 5'b11000, "R2 J");
    tx_step(1, 0, 0, 5'b10001, "R2 K");
    tx_step(1, 1, 5, 5'b00100, "R4 H");
    tx_step(1, 0, 5, tbl(5), "R1 data");

    // R5 invalid sequence with wrap, held on gaps
    test_inv = 1'b1;
    k = 0;
    for (int i = 0; i < 13; i++) begin
      tx_step(1, 1, 9, inv_at(k % 10), "R5 invalid");
      k++;
      if (i == 4) tx_step(1, 0, 9, tbl(9), "R5 hold");
    end
    tx_step(0, 1, 0, 5'b01101, "R3 T");
    tx_step(0, 1, 0, 5'b00111, "R3 R");
    tx_step(0, 1, 0, 5'b11111, "R2 idle");
    test_inv = 1'b0;

    // R6 receive start
    rx_step(5'b11111);
    chk("R6 idle crs", crs, 0);
    rx_step(5'b11000);
    chk("R6 J crs", crs, 0);
    rx_step(5'b10001);
    chk("R6 K crs", crs, 1);
    // R6 R9 R10 sweep every group except T
    for (int c = 0; c < 32; c++) begin
      int d;
      bit bad;
      if (c == 5'b01101) continue;
      d = data_of(5'(c));
      bad = (d < 0) && !is_ctl(5'(c));
      rx_step(5'(c));
      chk("R6 dv", rx_dv, d >= 0);
      chk("R6 rxd", rxd, d >= 0 ? d : 0);
      chk("R9 rx_er", rx_er, bad);
      chk("R6 crs", crs, 1);
    end
    chk("R10 inv flag", inv_flag, 1);
    chk("R10 halt flag", halt_flag, 1);

    // R8 T followed by non-R
    rx_step(5'b01101);
    chk("R8 T", {rx_er, crs}, 2'b01);
    rx_step(tbl(5));
    chk("R8 T no R", {rx_er, rx_dv, crs}, 3'b101);
    rx_step(tbl(6));
    chk("R8 resume", {rx_dv, rxd}, {1'b1, 4'h6});
    // R8 normal end
    rx_step(5'b01101);
    rx_step(5'b00111);
    chk("R8 crs off", crs, 0);
    rx_step(tbl(3));
    chk("R6 no dv outside", rx_dv, 0);

    // R7 false carrier
    rx_step(5'b11000);
    rx_step(5'b11111);
    chk("R7 fc", {fc, crs}, 2'b10);
    rx_step(5'b11111);
    chk("R7 fc pulse", fc, 0);

    // R11 clear, and set-wins-over-clear
    clr = 1'b1;
    rx_step(5'b11111);
    clr = 1'b0;
    chk("R11 cleared", {inv_flag, halt_flag}, 0);
    rx_step(5'b11111);
    chk("R11 stays clear", {inv_flag, halt_flag}, 0);
    rx_step(5'b00000);
    rx_step(5'b00100);
    chk("R10 outside packet", {inv_flag, halt_flag}, 2'b11);
    clr = 1'b1;
    rx_step(5'b00100);
    clr = 1'b0;
    chk("R11 set wins", {inv_flag, halt_flag}, 2'b01);
    rx_step(5'b11111);
    chk("R11 hold", {inv_flag, halt_flag}, 2'b01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule